// File: doc/BRIEF.md
# Interleaved Warp Issue Scheduler

This block is the issue stage of one streaming multiprocessor. It holds an in-order instruction stream for each of a configurable number of warps. Each warp presents its next instruction on its own valid/ready channel. A 32-thread warp takes four cycles to pass through eight execution lanes, so an issue slot opens every `WARP_SIZE/LANES` cycles. In each slot the block picks one ready warp by round-robin and sends that warp's single instruction downstream, tagged with the warp number. Warps take turns one instruction at a time. A warp does not keep the lanes until it reaches a memory access.

Each warp tracks one pending destination register: the one written by its most recent multiply-add. The result of a multiply-add becomes usable 24 cycles after it issues. An instruction that reads that register is held back until then. Stores wait on their data and address registers in the same way. With six warps each running a dependent chain, every slot is filled. With fewer warps, empty slots show up on a stall counter that runs next to an issued-instruction counter.

Top module: `warp_issue_sched`

## Requirements
- R1: Issue slots fall on the first cycle after reset release and then every 4 cycles. `inst_ready_o` is nonzero only in a slot cycle and has at most one bit set.
- R2: An instruction is taken when `inst_ready_o[w]` and `inst_valid_i[w]` are both high at a clock edge. In the next cycle `issue_valid_o` is high for exactly one cycle, carrying that warp's number, opcode class and destination tag.
- R3: Among ready warps, the grant goes to the first one found searching upward, with wrap, from the warp after the one issued last.
- R4: A multiply-add has opcode class 0 and reads sources a, b and c. If any of these equals the pending destination of the same warp's most recent multiply-add, it is held until 24 cycles after that multiply-add's issue cycle. It issues in that cycle at the earliest.
- R5: A store has opcode class 1 and reads source a (data) and source b (address). Its source c is ignored. It waits on the pending destination like a multiply-add does. It writes no register and leaves the pending destination unchanged.
- R6: A warp whose next instruction does not depend on its pending result may issue in consecutive slots when no other warp is ready.
- R7: With six warps each issuing a chain of dependent multiply-adds, every slot issues and the stall counter stays at zero.
- R8: `issued_cnt_o` increments by one for each issued instruction. `stall_cnt_o` increments by one for each slot with no issue. Both are updated in the cycle after the slot.
- R9: During reset nothing issues and both counters read zero. After reset no destination is pending and the round-robin search starts at warp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inst_valid_i | input | N_WARPS | Per-warp next instruction present |
| inst_op_i | input | N_WARPS | Per-warp opcode class: 0 multiply-add, 1 store |
| inst_dst_i | input | N_WARPS*TAG_W | Per-warp destination register tag |
| inst_src_a_i | input | N_WARPS*TAG_W | Per-warp source a tag (store data) |
| inst_src_b_i | input | N_WARPS*TAG_W | Per-warp source b tag (store address) |
| inst_src_c_i | input | N_WARPS*TAG_W | Per-warp source c tag (multiply-add addend) |
| inst_ready_o | output | N_WARPS | Per-warp instruction accepted this cycle |
| issue_valid_o | output | 1 | Instruction issued to the lanes |
| issue_warp_o | output | WID_W | Warp number of the issued instruction |
| issue_op_o | output | 1 | Opcode class of the issued instruction |
| issue_dst_o | output | TAG_W | Destination tag of the issued instruction |
| issued_cnt_o | output | PC_W | Count of issued instructions |
| stall_cnt_o | output | PC_W | Count of slots that issued nothing |

## Verification
The bench targets the exact release cycle of a dependency. If a dependent instruction is released one cycle late, the six-warp chain picks up stall slots. If it is released early, five warps issue where a stall is due. A store is given a source c that matches the pending tag and must not stall. A multiply-add that follows it with the same source c must stall, because the store must not have cleared or replaced the pending tag. A single warp with an independent pair followed by a dependent store checks back-to-back issue and the stall count. A sparse set of ready warps exposes a pointer that restarts at zero or fails to skip idle warps.

// File: rtl/wis_pkg.sv
package wis_pkg;

  typedef enum logic {
    OP_MAD   = 1'b0,
    OP_STORE = 1'b1
  } op_e;

endpackage

// File: rtl/wis_hazard.sv
// Per-warp pending-result tracker: one destination tag, one down-counter.
module wis_hazard
  import wis_pkg::*;
#(
  parameter int unsigned TAG_W   = 5,
  parameter int unsigned LATENCY = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TAG_W-1:0] load_tag_i,
  input  op_e              head_op_i,
  input  logic [TAG_W-1:0] head_src_a_i,
  input  logic [TAG_W-1:0] head_src_b_i,
  input  logic [TAG_W-1:0] head_src_c_i,
  output logic             hold_o
);

  localparam int unsigned CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic             pend_q;
  logic [TAG_W-1:0] tag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             src_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tag_q  <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      pend_q <= 1'b1;
      tag_q  <= load_tag_i;
      cnt_q  <= CNT_W'(LATENCY - 1);
    end else if (pend_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else             pend_q <= 1'b0;
    end
  end

  // store ignores source c
  always_comb begin
    src_hit = (head_src_a_i == tag_q) || (head_src_b_i == tag_q);
    if (head_op_i == OP_MAD && head_src_c_i == tag_q) src_hit = 1'b1;
  end

  assign hold_o = pend_q && (cnt_q != '0) && src_hit;

endmodule

// File: rtl/wis_rr_arb.sv
// Round-robin pick: first requester at or above ptr_i, with wrap.
module wis_rr_arb #(
  parameter int unsigned N    = 6,
  parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  input  logic [IDXW-1:0] ptr_i,
  output logic [N-1:0]    gnt_o,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);

  always_comb begin : pick
    int cand;
    gnt_o = '0;
    any_o = 1'b0;
    idx_o = '0;
    cand  = 0;
    for (int k = 0; k < int'(N); k++) begin
      cand = int'(ptr_i) + k;
      if (cand >= int'(N)) cand = cand - int'(N);
      if (!any_o && req_i[cand]) begin
        any_o       = 1'b1;
        gnt_o[cand] = 1'b1;
        idx_o       = IDXW'(cand);
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int unsigned N_WARPS   = 6,
  parameter int unsigned TAG_W     = 5,
  parameter int unsigned LANES     = 8,
  parameter int unsigned WARP_SIZE = 32,
  parameter int unsigned LATENCY   = 24,
  parameter int unsigned PC_W      = 16,
  localparam int unsigned WID_W    = (N_WARPS > 1) ? $clog2(N_WARPS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_WARPS-1:0]       inst_valid_i,
  input  logic [N_WARPS-1:0]       inst_op_i,
  input  logic [N_WARPS*TAG_W-1:0] inst_dst_i,
  input  logic [N_WARPS*TAG_W-1:0] inst_src_a_i,
  input  logic [N_WARPS*TAG_W-1:0] inst_src_b_i,
  input  logic [N_WARPS*TAG_W-1:0] inst_src_c_i,
  output logic [N_WARPS-1:0]       inst_ready_o,
  output logic                     issue_valid_o,
  output logic [WID_W-1:0]         issue_warp_o,
  output logic                     issue_op_o,
  output logic [TAG_W-1:0]         issue_dst_o,
  output logic [PC_W-1:0]          issued_cnt_o,
  output logic [PC_W-1:0]          stall_cnt_o
);

  localparam int unsigned SLOT_CYC = (WARP_SIZE / LANES > 0) ? WARP_SIZE / LANES : 1;
  localparam int unsigned PH_W     = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  // slot timing: one issue opportunity per warp pass through the lanes
  logic [PH_W-1:0] phase_q;
  logic            slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                phase_q <= '0;
    else if (phase_q == PH_W'(SLOT_CYC - 1))    phase_q <= '0;
    else                                        phase_q <= phase_q + 1'b1;
  end

  assign slot = (phase_q == '0);

  logic [N_WARPS-1:0] req, gnt, hold;
  logic               any_rdy, fire;
  logic [WID_W-1:0]   gnt_idx, ptr_q;

  for (genvar w = 0; w < N_WARPS; w++) begin : g_warp
    op_e head_op;
    assign head_op = op_e'(inst_op_i[w]);

    wis_hazard #(
      .TAG_W  (TAG_W),
      .LATENCY(LATENCY)
    ) u_haz (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (fire && gnt[w] && head_op == OP_MAD),
      .load_tag_i  (inst_dst_i[w*TAG_W +: TAG_W]),
      .head_op_i   (head_op),
      .head_src_a_i(inst_src_a_i[w*TAG_W +: TAG_W]),
      .head_src_b_i(inst_src_b_i[w*TAG_W +: TAG_W]),
      .head_src_c_i(inst_src_c_i[w*TAG_W +: TAG_W]),
      .hold_o      (hold[w])
    );

    assign req[w] = inst_valid_i[w] & ~hold[w];
  end

  wis_rr_arb #(
    .N   (N_WARPS),
    .IDXW(WID_W)
  ) u_arb (
    .req_i(req),
    .ptr_i(ptr_q),
    .gnt_o(gnt),
    .any_o(any_rdy),
    .idx_o(gnt_idx)
  );

  assign fire         = slot & any_rdy;
  assign inst_ready_o = slot ? gnt : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ptr_q <= '0;
    else if (fire && gnt_idx == WID_W'(N_WARPS - 1)) ptr_q <= '0;
    else if (fire)                               ptr_q <= gnt_idx + 1'b1;
  end

  // selected instruction fields
  op_e              sel_op;
  logic [TAG_W-1:0] sel_dst;

  always_comb begin
    sel_op  = OP_MAD;
    sel_dst = '0;
    for (int w = 0; w < int'(N_WARPS); w++) begin
      if (gnt[w]) begin
        sel_op  = op_e'(inst_op_i[w]);
        sel_dst = inst_dst_i[w*TAG_W +: TAG_W];
      end
    end
  end

  logic             iv_q;
  logic [WID_W-1:0] iw_q;
  op_e              iop_q;
  logic [TAG_W-1:0] idst_q;
  logic [PC_W-1:0]  issued_q, stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q     <= 1'b0;
      iw_q     <= '0;
      iop_q    <= OP_MAD;
      idst_q   <= '0;
      issued_q <= '0;
      stall_q  <= '0;
    end else begin
      iv_q <= fire;
      if (fire) begin
        iw_q     <= gnt_idx;
        iop_q    <= sel_op;
        idst_q   <= sel_dst;
        issued_q <= issued_q + 1'b1;
      end
      if (slot && !any_rdy) stall_q <= stall_q + 1'b1;
    end
  end

  assign issue_valid_o = iv_q;
  assign issue_warp_o  = iw_q;
  assign issue_op_o    = logic'(iop_q);
  assign issue_dst_o   = idst_q;
  assign issued_cnt_o  = issued_q;
  assign stall_cnt_o   = stall_q;

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int unsigned N_WARPS   = 6,
  parameter int unsigned TAG_W     = 5,
  parameter int unsigned LANES     = 8,
  parameter int unsigned WARP_SIZE = 32,
  parameter int unsigned LATENCY   = 24,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned WID_W     = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_WARPS-1:0]       inst_valid_i,
  input logic [N_WARPS-1:0]       inst_op_i,
  input logic [N_WARPS*TAG_W-1:0] inst_dst_i,
  input logic [N_WARPS*TAG_W-1:0] inst_src_a_i,
  input logic [N_WARPS*TAG_W-1:0] inst_src_b_i,
  input logic [N_WARPS*TAG_W-1:0] inst_src_c_i,
  input logic [N_WARPS-1:0]       inst_ready_o,
  input logic                     issue_valid_o,
  input logic [WID_W-1:0]         issue_warp_o,
  input logic                     issue_op_o,
  input logic [TAG_W-1:0]         issue_dst_o,
  input logic [PC_W-1:0]          issued_cnt_o,
  input logic [PC_W-1:0]          stall_cnt_o
);

  localparam int unsigned SLOT_CYC = (WARP_SIZE / LANES > 0) ? WARP_SIZE / LANES : 1;
  localparam int unsigned PH_W     = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int unsigned AGE_W    = $clog2(LATENCY + 1);

  logic [PH_W-1:0] ph;
  logic            took;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ph <= '0;
    else if (ph == PH_W'(SLOT_CYC - 1)) ph <= '0;
    else                                ph <= ph + 1'b1;
  end

  assign took = |(inst_ready_o & inst_valid_i);

  p_one_grant_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inst_ready_o));

  p_slot_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_ready_o != '0) |-> (ph == '0));

  p_ready_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_ready_o & ~inst_valid_i) == '0);

  p_issue_after_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    took |=> issue_valid_o);

  p_no_issue_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !took |=> !issue_valid_o);

  p_issued_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> issued_cnt_o == PC_W'($past(issued_cnt_o) + 1'b1));

  p_issued_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |-> $stable(issued_cnt_o));

  p_stall_when_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_cnt_o != $past(stall_cnt_o)) |-> ($past(ph) == '0 && !issue_valid_o));

  // independent age tracker per warp
  for (genvar w = 0; w < N_WARPS; w++) begin : g_raw
    logic             pend;
    logic [TAG_W-1:0] tag;
    logic [AGE_W-1:0] age;
    logic             blocked;
    logic [TAG_W-1:0] sa, sb, sc;

    assign sa = inst_src_a_i[w*TAG_W +: TAG_W];
    assign sb = inst_src_b_i[w*TAG_W +: TAG_W];
    assign sc = inst_src_c_i[w*TAG_W +: TAG_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend <= 1'b0;
        tag  <= '0;
        age  <= '0;
      end else if (inst_ready_o[w] && inst_valid_i[w] && !inst_op_i[w]) begin
        pend <= 1'b1;
        tag  <= inst_dst_i[w*TAG_W +: TAG_W];
        age  <= AGE_W'(1);
      end else if (pend && age < AGE_W'(LATENCY)) begin
        age <= age + 1'b1;
      end
    end

    assign blocked = pend && (age < AGE_W'(LATENCY)) &&
                     (sa == tag || sb == tag || (!inst_op_i[w] && sc == tag));

    p_raw_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inst_ready_o[w] |-> !blocked);
  end

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .N_WARPS  (N_WARPS),
  .TAG_W    (TAG_W),
  .LANES    (LANES),
  .WARP_SIZE(WARP_SIZE),
  .LATENCY  (LATENCY),
  .PC_W     (PC_W),
  .WID_W    (WID_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inst_valid_i (inst_valid_i),
  .inst_op_i    (inst_op_i),
  .inst_dst_i   (inst_dst_i),
  .inst_src_a_i (inst_src_a_i),
  .inst_src_b_i (inst_src_b_i),
  .inst_src_c_i (inst_src_c_i),
  .inst_ready_o (inst_ready_o),
  .issue_valid_o(issue_valid_o),
  .issue_warp_o (issue_warp_o),
  .issue_op_o   (issue_op_o),
  .issue_dst_o  (issue_dst_o),
  .issued_cnt_o (issued_cnt_o),
  .stall_cnt_o  (stall_cnt_o)
);

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;

  localparam int NW   = 6;
  localparam int TW   = 5;
  localparam int LAT  = 24;
  localparam int SLOT = 4;
  localparam int PCW  = 16;
  localparam int IW   = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_ni;
  logic [NW-1:0]     inst_valid_i, inst_op_i, inst_ready_o;
  logic [NW*TW-1:0]  inst_dst_i, inst_src_a_i, inst_src_b_i, inst_src_c_i;
  logic              issue_valid_o, issue_op_o;
  logic [IW-1:0]     issue_warp_o;
  logic [TW-1:0]     issue_dst_o;
  logic [PCW-1:0]    issued_cnt_o, stall_cnt_o;

  warp_issue_sched #(
    .N_WARPS(NW), .TAG_W(TW), .LANES(8), .WARP_SIZE(32), .LATENCY(LAT), .PC_W(PCW)
  ) i_warp_issue_sched (
    .clk_i(clk), .rst_ni(rst_ni),
    .inst_valid_i(inst_valid_i), .inst_op_i(inst_op_i), .inst_dst_i(inst_dst_i),
    .inst_src_a_i(inst_src_a_i), .inst_src_b_i(inst_src_b_i), .inst_src_c_i(inst_src_c_i),
    .inst_ready_o(inst_ready_o), .issue_valid_o(issue_valid_o), .issue_warp_o(issue_warp_o),
    .issue_op_o(issue_op_o), .issue_dst_o(issue_dst_o),
    .issued_cnt_o(issued_cnt_o), .stall_cnt_o(stall_cnt_o)
  );

  // entry: [20] op, [19:15] dst, [14:10] a, [9:5] b, [4:0] c
  logic [20:0] prog [NW][$];

  int errors = 0, checks = 0;
  int pend [NW], ptag [NW], rdy_at [NW];
  int ptr, cyc;
  int exp_iv, exp_iw, exp_op, exp_dst, exp_issued, exp_stall;

  function automatic logic [20:0] mk(int op, int d, int a, int b, int c);
    return {op[0], d[4:0], a[4:0], b[4:0], c[4:0]};
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic drive_inputs();
    for (int w = 0; w < NW; w++) begin
      logic [20:0] e;
      e = (prog[w].size() > 0) ? prog[w][0] : '0;
      inst_valid_i[w]           = (prog[w].size() > 0);
      inst_op_i[w]              = e[20];
      inst_dst_i[w*TW +: TW]    = e[19:15];
      inst_src_a_i[w*TW +: TW]  = e[14:10];
      inst_src_b_i[w*TW +: TW]  = e[9:5];
      inst_src_c_i[w*TW +: TW]  = e[4:0];
    end
  endtask

  function automatic bit model_ready(int w);
    logic [20:0] e;
    bit hit;
    if (prog[w].size() == 0) return 0;
    e = prog[w][0];
    if (!pend[w] || cyc >= rdy_at[w]) return 1;
    hit = (int'(e[14:10]) == ptag[w]) || (int'(e[9:5]) == ptag[w]);
    if (!e[20] && int'(e[4:0]) == ptag[w]) hit = 1;
    return !hit;
  endfunction

  task automatic begin_reset();
    @(posedge clk); #1;
    rst_ni = 1'b0;
    for (int w = 0; w < NW; w++) prog[w].delete();
    drive_inputs();
    repeat (2) begin
      @(negedge clk);
      chk("R9", int'(issue_valid_o), 0, "issue_valid in reset");
      chk("R9", int'(issued_cnt_o), 0, "issued count in reset");
      chk("R9", int'(stall_cnt_o), 0, "stall count in reset");
    end
  endtask

  task automatic end_reset();
    for (int w = 0; w < NW; w++) begin pend[w] = 0; ptag[w] = 0; rdy_at[w] = 0; end
    ptr = 0; cyc = 0;
    exp_iv = 0; exp_iw = 0; exp_op = 0; exp_dst = 0; exp_issued = 0; exp_stall = 0;
    @(posedge clk); #1;
    drive_inputs();
    rst_ni = 1'b1;
  endtask

  task automatic run(int n);
    repeat (n) begin
      int g;
      bit slot;
      @(negedge clk);
      slot = (cyc % SLOT) == 0;
      g = -1;
      if (slot)
        for (int k = 0; k < NW; k++) begin
          int w;
          w = (ptr + k) % NW;
          if (g < 0 && model_ready(w)) g = w;
        end
      chk("R1", int'(inst_ready_o), (g >= 0) ? (1 << g) : 0, "ready vector");
      chk("R2", int'(issue_valid_o), exp_iv, "issue_valid");
      if (exp_iv != 0) begin
        chk("R2", int'(issue_warp_o), exp_iw, "issue_warp");
        chk("R2", int'(issue_op_o), exp_op, "issue_op");
        chk("R2", int'(issue_dst_o), exp_dst, "issue_dst");
      end
      chk("R8", int'(issued_cnt_o), exp_issued, "issued count");
      chk("R8", int'(stall_cnt_o), exp_stall, "stall count");
      @(posedge clk);
      exp_iv = 0;
      if (g >= 0) begin
        logic [20:0] e;
        e = prog[g].pop_front();
        exp_iv = 1; exp_iw = g; exp_op = int'(e[20]); exp_dst = int'(e[19:15]);
        exp_issued++;
        if (!e[20]) begin pend[g] = 1; ptag[g] = int'(e[19:15]); rdy_at[g] = cyc + LAT; end
        ptr = (g + 1) % NW;
      end else if (slot) begin
        exp_stall++;
      end
      cyc++;
      #1 drive_inputs();
    end
  endtask

  task automatic scenarios();
    // R7: six dependent chains fill every slot
    begin_reset();
    for (int w = 0; w < NW; w++) repeat (8) prog[w].push_back(mk(0, 1, 1, 2, 3));
    end_reset();
    run(1);
    chk("R9", int'(issue_warp_o), 0, "first grant after reset");
    run(188);
    chk("R7", int'(issued_cnt_o), 48, "issued after six chains");
    chk("R7", int'(stall_cnt_o), 0, "stalls after six chains");
    run(8);

    // R4: five dependent chains leave one empty slot per round
    begin_reset();
    for (int w = 0; w < 5; w++) repeat (4) prog[w].push_back(mk(0, 2, 2, 3, 4));
    end_reset();
    run(25);
    chk("R4", int'(issued_cnt_o), 6, "issued, five chains");
    chk("R4", int'(stall_cnt_o), 1, "stalls, five chains");
    run(80);

    // R6 then R5: independent pair back-to-back, store waits on r6
    begin_reset();
    prog[2].push_back(mk(0, 5, 7, 8, 9));
    prog[2].push_back(mk(0, 6, 7, 8, 9));
    prog[2].push_back(mk(1, 0, 6, 10, 0));
    end_reset();
    run(5);
    chk("R6", int'(issued_cnt_o), 2, "independent back-to-back");
    run(24);
    chk("R5", int'(issued_cnt_o), 3, "store issued after latency");
    chk("R5", int'(stall_cnt_o), 5, "store wait stalls");
    chk("R5", int'(issue_op_o), 1, "store opcode");
    run(4);

    // R5: store source c ignored and pending tag kept; R4: addend hazard
    begin_reset();
    prog[0].push_back(mk(0, 3, 1, 1, 1));
    prog[0].push_back(mk(1, 0, 4, 5, 3));
    prog[0].push_back(mk(0, 7, 4, 5, 3));
    end_reset();
    run(5);
    chk("R5", int'(issued_cnt_o), 2, "store not held by source c");
    chk("R5", int'(stall_cnt_o), 0, "no stall before store");
    run(21);
    chk("R4", int'(issued_cnt_o), 3, "addend hazard released");
    chk("R4", int'(stall_cnt_o), 4, "addend hazard stalls");
    chk("R4", int'(issue_dst_o), 7, "released instruction dst");

    // R3: sparse round-robin
    begin_reset();
    for (int w = 0; w < NW; w++)
      if (w == 0 || w == 2 || w == 3)
        repeat (4) prog[w].push_back(mk(0, 10 + w, 20, 21, 22));
    end_reset();
    run(5);
    chk("R3", int'(issue_warp_o), 2, "skip idle warp 1");
    run(4);
    chk("R3", int'(issue_warp_o), 3, "next after warp 2");
    run(4);
    chk("R3", int'(issue_warp_o), 0, "wrap to warp 0");
    run(40);
  endtask

  initial begin
    bit timeout;
    timeout = 0;
    rst_ni = 1'b0;
    inst_valid_i = '0; inst_op_i = '0;
    inst_dst_i = '0; inst_src_a_i = '0; inst_src_b_i = '0; inst_src_c_i = '0;
    fork
      scenarios();
      begin
        repeat (20000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule